// File: doc/BRIEF.md
# Second-Order Recursive Sample Filter

This block is an 8-bit fixed-point biquad filter that sits between an analogue-to-digital converter and a digital-to-analogue converter. Each pulse on the sample tick starts one sample period. The block sends a one-cycle convert command to the ADC and waits as long as needed for the converter's ready strobe. It then captures the new input sample and forms the output from the current input, the two previous inputs and the two previous outputs. It presents the result to the DAC port with a one-cycle write strobe. Last, it shifts its four delay registers.

A select input chooses between two coefficient sets that share the same feedback taps. One set gives a low-pass response and the other a high-pass response, both with a 100 Hz corner when ticks arrive every 1.6 ms. Samples are signed two's-complement by default. The `OFFSET_BINARY` parameter inverts the sign bit at the input and at the output, for converters that use offset-binary codes. The five products are summed sequentially, one tap per clock, through a single multiplier.

Top module: `biquad8_filter`

## Requirements
- R1: After reset, `dac_data_o`, `dac_wr_o`, `adc_conv_o` and `overrun_o` are 0. All four delay registers are zero, so the first output after reset depends only on the first input.
- R2: A `tick_i` pulse while idle produces exactly one single-cycle `adc_conv_o` pulse. The block then waits for `adc_ready_i` for any number of cycles and issues no output meanwhile.
- R3: With `hp_sel_i`=0 (low-pass), the output is y = t(19,x0) + t(37,x1) + t(19,x2) + t(86,y1) + t(-32,y2). The coefficients are Q1.7 integers, x1/x2 are the previous inputs and y1/y2 are the previous outputs.
- R4: With `hp_sel_i`=1 (high-pass), the three feed-forward coefficients become 62, -123 and 62. The feedback coefficients 86 and -32 stay the same.
- R5: Each term t(c,s) is the 16-bit signed product c*s shifted arithmetically right by 7, which is truncation toward minus infinity. The five terms sum in a 16-bit signed accumulator.
- R6: The sum saturates to the range -128..+127 before output and never wraps.
- R7: Each new result appears on `dac_data_o` together with a one-cycle `dac_wr_o` pulse. `dac_data_o` does not change in any other cycle.
- R8: After each output, y2 takes y1, y1 takes the saturated output, x2 takes x1 and x1 takes the input just captured.
- R9: `hp_sel_i` is sampled only in the cycle that accepts the tick. Changes during the rest of the period do not affect that output.
- R10: A `tick_i` pulse that arrives while a sample period is in progress is not acted on. It sets `overrun_o`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample-period start pulse |
| hp_sel_i | input | 1 | Coefficient set: 0 low-pass, 1 high-pass |
| adc_conv_o | output | 1 | Convert command to the ADC, one cycle |
| adc_ready_i | input | 1 | ADC conversion done |
| adc_data_i | input | 8 | ADC sample |
| dac_data_o | output | 8 | Filter output to the DAC |
| dac_wr_o | output | 1 | DAC write strobe, one cycle |
| overrun_o | output | 1 | Sticky tick-while-busy flag |

## Verification
On every cycle, the assertions check several control properties. The convert command is a single-cycle pulse. The block stays in its wait state until ready arrives. The DAC word holds between write strobes. The latched coefficient select and the overrun flag cannot change once set. The accumulator tap index stays in range. The arithmetic itself can only be shown by the bench's scenarios, which compare each output against an independent integer model. These scenarios cover impulse and step responses in both modes, saturation at both rails, a select change in the middle of a period, a long converter wait and an overrun.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_MAC  = 2'd2,
        S_OUT  = 2'd3
    } seq_state_e;

    localparam int NUM_TAPS = 5;
    localparam int TAP_W    = $clog2(NUM_TAPS);
endpackage

// File: rtl/biquad_coef_rom.sv
module biquad_coef_rom #(
    parameter int DATA_W = 8,
    parameter int TAP_W  = 3
) (
    input  logic                     hp_i,
    input  logic [TAP_W-1:0]         tap_i,
    output logic signed [DATA_W-1:0] coef_o
);
    // Q1.7 coefficients; the second feedback tap is stored already negated
    always_comb begin
        unique case (tap_i)
            TAP_W'(0): coef_o = hp_i ? DATA_W'(62)   : DATA_W'(19);
            TAP_W'(1): coef_o = hp_i ? -DATA_W'(123) : DATA_W'(37);
            TAP_W'(2): coef_o = hp_i ? DATA_W'(62)   : DATA_W'(19);
            TAP_W'(3): coef_o = DATA_W'(86);
            TAP_W'(4): coef_o = -DATA_W'(32);
            default:   coef_o = '0;
        endcase
    end
endmodule

// File: rtl/biquad_tap_mul.sv
module biquad_tap_mul #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 7,
    parameter int ACC_W  = 16
) (
    input  logic signed [DATA_W-1:0] coef_i,
    input  logic signed [DATA_W-1:0] samp_i,
    output logic signed [ACC_W-1:0]  term_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod   = coef_i * samp_i;
        term_o = ACC_W'(prod >>> FRAC_W);
    end
endmodule

// File: rtl/biquad_sat.sv
module biquad_sat #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    output logic signed [DATA_W-1:0] sat_o
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = -ACC_W'(1 << (DATA_W - 1));

    always_comb begin
        if (acc_i > HI)      sat_o = HI[DATA_W-1:0];
        else if (acc_i < LO) sat_o = LO[DATA_W-1:0];
        else                 sat_o = acc_i[DATA_W-1:0];
    end
endmodule

// File: rtl/biquad8_filter.sv
module biquad8_filter #(
    parameter int DATA_W        = 8,
    parameter int FRAC_W        = 7,
    parameter int ACC_W         = 16,
    parameter bit OFFSET_BINARY = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              hp_sel_i,
    output logic              adc_conv_o,
    input  logic              adc_ready_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic [DATA_W-1:0] dac_data_o,
    output logic              dac_wr_o,
    output logic              overrun_o
);
    import biquad_pkg::*;

    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    typedef struct packed {
        seq_state_e               st;
        logic [TAP_W-1:0]         tap;
        logic                     hp;
        logic                     conv;
        logic                     wr;
        logic                     ovr;
        logic signed [DATA_W-1:0] xn;
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] x2;
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
        logic signed [DATA_W-1:0] dac;
        logic signed [ACC_W-1:0]  acc;
    } regs_t;

    regs_t r_q, r_d;

    logic signed [DATA_W-1:0] samp_in;
    logic signed [DATA_W-1:0] tap_samp;
    logic signed [DATA_W-1:0] tap_coef;
    logic signed [ACC_W-1:0]  tap_term;
    logic signed [DATA_W-1:0] y_sat;

    // converter code format selected at elaboration
    generate
        if (OFFSET_BINARY) begin : g_offbin
            assign samp_in    = {~adc_data_i[DATA_W-1], adc_data_i[DATA_W-2:0]};
            assign dac_data_o = {~r_q.dac[DATA_W-1], r_q.dac[DATA_W-2:0]};
        end else begin : g_twos
            assign samp_in    = adc_data_i;
            assign dac_data_o = r_q.dac;
        end
    endgenerate

    always_comb begin
        unique case (r_q.tap)
            TAP_W'(0): tap_samp = r_q.xn;
            TAP_W'(1): tap_samp = r_q.x1;
            TAP_W'(2): tap_samp = r_q.x2;
            TAP_W'(3): tap_samp = r_q.y1;
            TAP_W'(4): tap_samp = r_q.y2;
            default:   tap_samp = '0;
        endcase
    end

    biquad_coef_rom #(.DATA_W(DATA_W), .TAP_W(TAP_W)) coef_i (
        .hp_i   (r_q.hp),
        .tap_i  (r_q.tap),
        .coef_o (tap_coef)
    );

    biquad_tap_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) mul_i (
        .coef_i (tap_coef),
        .samp_i (tap_samp),
        .term_o (tap_term)
    );

    biquad_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W)) sat_i (
        .acc_i (r_q.acc),
        .sat_o (y_sat)
    );

    always_comb begin
        r_d      = r_q;
        r_d.conv = 1'b0;
        r_d.wr   = 1'b0;
        if (tick_i && r_q.st != S_IDLE) r_d.ovr = 1'b1;
        unique case (r_q.st)
            S_IDLE: if (tick_i) begin
                r_d.hp   = hp_sel_i;
                r_d.conv = 1'b1;
                r_d.st   = S_WAIT;
            end
            S_WAIT: if (adc_ready_i) begin
                r_d.xn  = samp_in;
                r_d.acc = '0;
                r_d.tap = '0;
                r_d.st  = S_MAC;
            end
            S_MAC: begin
                r_d.acc = r_q.acc + tap_term;
                r_d.tap = r_q.tap + TAP_W'(1);
                if (r_q.tap == LAST_TAP) r_d.st = S_OUT;
            end
            S_OUT: begin
                r_d.dac = y_sat;
                r_d.wr  = 1'b1;
                r_d.y2  = r_q.y1;
                r_d.y1  = y_sat;
                r_d.x2  = r_q.x1;
                r_d.x1  = r_q.xn;
                r_d.st  = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_conv_o = r_q.conv;
    assign dac_wr_o   = r_q.wr;
    assign overrun_o  = r_q.ovr;

    p_conv_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_conv_o |=> !adc_conv_o);

    p_wait_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_WAIT && !adc_ready_i) |=> (r_q.st == S_WAIT && !dac_wr_o));

    p_tap_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_MAC) |-> (r_q.tap <= LAST_TAP));

    p_dac_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_wr_o |-> $stable(dac_data_o));

    p_sel_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != S_IDLE) |=> $stable(r_q.hp));

    p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |=> overrun_o);
endmodule

// File: tb/biquad8_filter_tb_top.sv
module biquad8_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hp_sel = 1'b0;
    logic       adc_conv;
    logic       adc_ready = 1'b0;
    logic [7:0] adc_data = '0;
    logic [7:0] dac_data;
    logic       dac_wr;
    logic       overrun;

    int n_checks = 0;
    int n_fail = 0;
    int mx1, mx2, my1, my2;

    always #2 clk = ~clk;

    biquad8_filter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .hp_sel_i    (hp_sel),
        .adc_conv_o  (adc_conv),
        .adc_ready_i (adc_ready),
        .adc_data_i  (adc_data),
        .dac_data_o  (dac_data),
        .dac_wr_o    (dac_wr),
        .overrun_o   (overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int term(input int c, input int s);
        return (c * s) >>> 7;
    endfunction

    // independent model of the requirement equations
    function automatic int model_step(input int x, input bit hp);
        int acc, y;
        acc = hp ? term(62, x) + term(-123, mx1) + term(62, mx2)
                 : term(19, x) + term(37, mx1) + term(19, mx2);
        acc += term(86, my1) + term(-32, my2);
        y = (acc > 127) ? 127 : (acc < -128) ? -128 : acc;
        my2 = my1; my1 = y; mx2 = mx1; mx1 = x;
        return y;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    task automatic run_sample(input int x, input bit hp, input bit hp_later,
                              input int ready_delay, input bit extra_tick,
                              output int y);
        int got_wr;
        @(negedge clk);
        hp_sel = hp;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        hp_sel = hp_later;
        check("R2 conv pulse", int'(adc_conv), 1);
        @(negedge clk);
        check("R2 conv single", int'(adc_conv), 0);
        for (int i = 0; i < ready_delay; i++) begin
            tick = extra_tick && (i == 0);
            @(negedge clk);
            tick = 1'b0;
            if (adc_conv || dac_wr) check("R2 idle while waiting", 1, 0);
        end
        adc_data = 8'(x);
        adc_ready = 1'b1;
        @(negedge clk);
        adc_ready = 1'b0;
        got_wr = 0;
        for (int i = 0; i < 20 && !got_wr; i++) begin
            @(negedge clk);
            if (dac_wr) got_wr = 1;
        end
        check("R7 write strobe", got_wr, 1);
        y = int'($signed(dac_data));
        @(negedge clk);
        check("R7 strobe single", int'(dac_wr), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 dac_data", int'(dac_data), 0);
        check("R1 dac_wr", int'(dac_wr), 0);
        check("R1 adc_conv", int'(adc_conv), 0);
        check("R1 overrun", int'(overrun), 0);
    endtask

    task automatic t_lp_impulse();
        int y, e;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            e = model_step((k == 0) ? 100 : 0, 1'b0);
            run_sample((k == 0) ? 100 : 0, 1'b0, 1'b0, 1, 1'b0, y);
            if (k == 0) check("R1 R3 first output", y, 14);
            else check("R3 R8 lp impulse", y, e);
        end
    endtask

    task automatic t_lp_mixed();
        int y, e;
        int xs[6] = '{-90, 45, 120, -128, 7, 127};
        for (int k = 0; k < 6; k++) begin
            e = model_step(xs[k], 1'b0);
            run_sample(xs[k], 1'b0, 1'b0, 2, 1'b0, y);
            check("R3 R5 lp mixed", y, e);
        end
    endtask

    task automatic t_hp_step();
        int y, e;
        do_reset();
        for (int k = 0; k < 6; k++) begin
            e = model_step(80, 1'b1);
            run_sample(80, 1'b1, 1'b1, 1, 1'b0, y);
            check("R4 R8 hp step", y, e);
        end
    endtask

    task automatic t_saturate();
        int y;
        do_reset();
        run_sample(-128, 1'b1, 1'b1, 1, 1'b0, y);
        check("R5 hp neg term", y, model_step(-128, 1'b1));
        run_sample(127, 1'b1, 1'b1, 1, 1'b0, y);
        check("R6 positive rail", y, 127);
        do_reset();
        run_sample(127, 1'b1, 1'b1, 1, 1'b0, y);
        check("R5 hp pos term", y, 61);
        run_sample(-128, 1'b1, 1'b1, 1, 1'b0, y);
        check("R6 negative rail", y, -128);
    endtask

    task automatic t_sel_latch();
        int y, e;
        do_reset();
        e = model_step(100, 1'b0);
        run_sample(100, 1'b0, 1'b1, 3, 1'b0, y);
        check("R9 lp kept after select change", y, e);
        e = model_step(-60, 1'b1);
        run_sample(-60, 1'b1, 1'b0, 3, 1'b0, y);
        check("R9 hp kept after select change", y, e);
    endtask

    task automatic t_long_wait();
        int y, e;
        e = model_step(33, 1'b0);
        run_sample(33, 1'b0, 1'b0, 40, 1'b0, y);
        check("R2 long converter wait", y, e);
    endtask

    task automatic t_overrun();
        int y, e;
        do_reset();
        e = model_step(50, 1'b0);
        run_sample(50, 1'b0, 1'b0, 3, 1'b1, y);
        check("R10 overrun set", int'(overrun), 1);
        check("R10 stray tick has no effect on output", y, e);
        @(negedge clk);
        check("R10 no extra convert", int'(adc_conv), 0);
        e = model_step(-20, 1'b0);
        run_sample(-20, 1'b0, 1'b0, 1, 1'b0, y);
        check("R10 overrun sticky", int'(overrun), 1);
        check("R10 next sample normal", y, e);
        do_reset();
        check("R10 cleared by reset", int'(overrun), 0);
    endtask

    initial begin
        t_reset();
        t_lp_impulse();
        t_lp_mixed();
        t_hp_step();
        t_saturate();
        t_sel_latch();
        t_long_wait();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule